// File: doc/BRIEF.md
# Eight-Channel Slaved Match Timer

This block provides eight match channels, numbered 4 to 11. Each has its own counter, match register and control register. A channel can advance its own counter on one of several externally supplied rate ticks. It can also leave its counter idle and compare its match value against the counter of a master channel. Channels 4, 8 and 10 are masters and always run their own counters. Channels 5 to 7 follow channel 4, channel 9 follows channel 8, and channel 11 follows channel 10.

A match occurs when the counter being watched advances to a value equal to the channel's match register. Each match can set an event bit, if that channel's interrupt enable is set. All event bits feed one combined interrupt line. The control register selects three more behaviours:
- clearing the channel's own counter on a match;
- keeping the match armed after a hit, or firing once;
- on channels 9 and 11 only, capturing the preceding channel's counter into a snapshot register when the channel's counter is read.

Software reaches the block through a single-cycle register write and read port. Read data appears one cycle after the read strobe.

Top module: `xmatch_timer`

## Requirements
- R1: After reset, every counter, match, control, enable, status and snapshot register reads zero, and irq is low.
- R2: Control bits [2:0] hold a rate code r. For r from 1 to 7, a running counter advances by one on each cycle where rate_tick[r] is high. Code 0 stops the counter, and it holds its value.
- R3: Register addresses are: match of channel 4+i at i; counter at 8+i; control at 16+i; status at 24; enable at 25; snapshot at 26. Unmapped addresses read zero. rdata holds the addressed value from the clock edge that samples rd_en.
- R4: Channels 4 to 7 keep control bits [7:0] and channels 8 to 11 keep bits [9:0]. The other written bits read back as zero.
- R5: On channels 8 to 11, control bit 8 forces rate code 0 and overrides bits [2:0]. On channels 4 to 7, writing bit 8 has no effect.
- R6: Control bit 7 makes a non-master channel run its own counter. With bit 7 clear, the channel's counter stays still and its match compares against its master's counter (5,6,7 follow 4; 9 follows 8; 11 follows 10). Masters count regardless of bit 7.
- R7: A match is a selected tick on which the watched counter's incremented value equals the match register. A match on an armed channel whose enable bit (enable register bit i for channel 4+i) is set sets status bit i.
- R8: With control bit 3 set, a match on a channel running its own counter loads that counter with zero instead of the incremented value.
- R9: With control bit 6 clear, a channel disarms after its first match. Later equal values raise no event until its match register is written. With bit 6 set, it stays armed.
- R10: With control bit 9 set on channel 9 or 11, reading that channel's counter copies the counter of channel 8 or 10 into the snapshot register. No other access changes the snapshot.
- R11: irq is high while any status bit is set. Writing ones to the status register clears those bits. irq falls only after the last pending bit is cleared.
- R12: A counter write loads the written value on that clock edge, overriding any tick in the same cycle. Counting resumes from it on the next selected tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Register address |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data, registered |
| rate_tick | input | NRATE-1 | Rate tick pulses, indices 1 to NRATE-1 |
| irq | output | 1 | Combined event interrupt |

## Verification
The assertions assume the following about the inputs:
- each access is a single-cycle strobe with a stable address;
- rate ticks are one-cycle pulses whose timing relative to register writes is arbitrary.

The checker relates each counter's next value to the write strobe and the rate code it saw, so it does not depend on tick spacing.

The stimulus keeps to these assumptions. It:
- drives every strobe and tick for exactly one cycle, starting at the falling edge;
- keeps ticks and accesses in separate cycles, except in the single test where a counter write and a tick coincide on purpose;
- sweeps every rate code against every tick line on one channel.

// File: rtl/xmt_pkg.sv
package xmt_pkg;
   localparam int NCH       = 8;
   localparam int NARROW_CH = 4;
   localparam int CTRL_W    = 10;
   localparam int RATE_W    = 3;

   localparam int B_RST_ON_HIT = 3;
   localparam int B_PERIODIC   = 6;
   localparam int B_OWN        = 7;
   localparam int B_FORCE_STOP = 8;
   localparam int B_SNAP_EN    = 9;

   typedef enum logic [1:0] {
      GRP_MATCH = 2'd0,
      GRP_CNT   = 2'd1,
      GRP_CTRL  = 2'd2,
      GRP_MISC  = 2'd3
   } grp_e;

   localparam logic [2:0] MISC_STATUS = 3'd0;
   localparam logic [2:0] MISC_IEN    = 3'd1;
   localparam logic [2:0] MISC_SNAP   = 3'd2;

   function automatic int master_of(input int ch);
      if (ch < 4)      return 0;
      else if (ch < 6) return 4;
      else             return 6;
   endfunction

   function automatic bit is_master(input int ch);
      return master_of(ch) == ch;
   endfunction
endpackage

// File: rtl/xmt_channel.sv
module xmt_channel #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_we,
   input  logic             match_we,
   input  logic [CNT_W-1:0] wdata,
   input  logic             own_adv,
   input  logic             src_adv,
   input  logic [CNT_W-1:0] src_inc,
   input  logic             rst_on_hit,
   input  logic             periodic,
   output logic             hit,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] match_q
);
   logic armed_q;
   logic equal_c;

   assign equal_c = src_adv && (src_inc == match_q);
   assign hit     = equal_c && armed_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         match_q <= '0;
         armed_q <= 1'b1;
      end else if (match_we) begin
         match_q <= wdata;
         armed_q <= 1'b1;
      end else if (hit && !periodic) begin
         armed_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (cnt_we) begin
         cnt_q <= wdata;
      end else if (own_adv) begin
         if (rst_on_hit && hit) cnt_q <= '0;
         else                   cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/xmt_event.sv
module xmt_event #(
   parameter int NEV = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NEV-1:0] hit,
   input  logic [NEV-1:0] ien,
   input  logic           clr_we,
   input  logic [NEV-1:0] clr_mask,
   output logic [NEV-1:0] events_q,
   output logic           irq
);
   logic [NEV-1:0] keep_c;

   assign keep_c = clr_we ? ~clr_mask : '1;

   always_ff @(posedge clk) begin
      if (!rst_n) events_q <= '0;
      else        events_q <= (events_q & keep_c) | (hit & ien);
   end

   assign irq = |events_q;
endmodule

// File: rtl/xmt_rdmux.sv
module xmt_rdmux import xmt_pkg::*; #(
   parameter int CNT_W = 32
) (
   input  logic [1:0]                    grp,
   input  logic [2:0]                    idx,
   input  logic [NCH-1:0][CNT_W-1:0]     match_q,
   input  logic [NCH-1:0][CNT_W-1:0]     cnt_q,
   input  logic [NCH-1:0][CTRL_W-1:0]    ctrl_q,
   input  logic [NCH-1:0]                events_q,
   input  logic [NCH-1:0]                ien_q,
   input  logic [CNT_W-1:0]              snap_q,
   output logic [CNT_W-1:0]              data
);
   always_comb begin
      data = '0;
      unique case (grp)
         GRP_MATCH: data = match_q[idx];
         GRP_CNT:   data = cnt_q[idx];
         GRP_CTRL:  data = CNT_W'(ctrl_q[idx]);
         default: begin
            if (idx == MISC_STATUS)    data = CNT_W'(events_q);
            else if (idx == MISC_IEN)  data = CNT_W'(ien_q);
            else if (idx == MISC_SNAP) data = snap_q;
            else                       data = '0;
         end
      endcase
   end
endmodule

// File: rtl/xmatch_timer.sv
module xmatch_timer import xmt_pkg::*; #(
   parameter int CNT_W = 32,
   parameter int NRATE = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [4:0]       addr,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] rdata,
   input  logic [NRATE-1:1] rate_tick,
   output logic             irq
);
   localparam int IDX_W = 3;

   if (CNT_W < CTRL_W) begin : g_bad_width
      $error("xmatch_timer: CNT_W must cover the control register");
   end
   if (NRATE < 2 || NRATE > (1 << RATE_W)) begin : g_bad_rate
      $error("xmatch_timer: NRATE must be between 2 and 8");
   end

   logic [1:0]             grp;
   logic [IDX_W-1:0]       idx;
   logic [NCH-1:0]         cnt_we, match_we, ctrl_we;
   logic [NCH-1:0][CTRL_W-1:0] ctrl_q;
   logic [NCH-1:0]         adv, runs_own, own_adv, src_adv, hit;
   logic [NCH-1:0][CNT_W-1:0] cnt_q, match_q, src_inc;
   logic [NCH-1:0]         ien_q, events_q;
   logic [CNT_W-1:0]       snap_q, rd_data_c;
   logic                   status_clr, ien_we;

   assign grp        = addr[4:3];
   assign idx        = addr[2:0];
   assign status_clr = wr_en && grp == GRP_MISC && idx == MISC_STATUS;
   assign ien_we     = wr_en && grp == GRP_MISC && idx == MISC_IEN;

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      localparam int  M    = master_of(i);
      localparam bit  MST  = is_master(i);
      localparam bit  WIDE = (i >= NARROW_CH);
      localparam logic [CTRL_W-1:0] KEEP = WIDE ? {CTRL_W{1'b1}} : CTRL_W'(8'hFF);

      logic [RATE_W-1:0] rc;
      logic              adv_b;

      assign cnt_we[i]   = wr_en && grp == GRP_CNT   && idx == IDX_W'(i);
      assign match_we[i] = wr_en && grp == GRP_MATCH && idx == IDX_W'(i);
      assign ctrl_we[i]  = wr_en && grp == GRP_CTRL  && idx == IDX_W'(i);

      always_ff @(posedge clk) begin
         if (!rst_n)          ctrl_q[i] <= '0;
         else if (ctrl_we[i]) ctrl_q[i] <= wdata[CTRL_W-1:0] & KEEP;
      end

      always_comb begin
         rc = ctrl_q[i][RATE_W-1:0];
         if (WIDE && ctrl_q[i][B_FORCE_STOP]) rc = '0;
         adv_b = 1'b0;
         for (int r = 1; r < NRATE; r++) begin
            if (rc == RATE_W'(r)) adv_b = rate_tick[r];
         end
      end

      assign adv[i]      = adv_b;
      assign runs_own[i] = ctrl_q[i][B_OWN] || MST;
      assign own_adv[i]  = runs_own[i] && adv[i];

      if (MST) begin : g_self
         assign src_adv[i] = own_adv[i] && !cnt_we[i];
         assign src_inc[i] = cnt_q[i] + 1'b1;
      end else begin : g_slave
         assign src_adv[i] = runs_own[i] ? (own_adv[i] && !cnt_we[i])
                                         : (own_adv[M] && !cnt_we[M]);
         assign src_inc[i] = runs_own[i] ? (cnt_q[i] + 1'b1) : (cnt_q[M] + 1'b1);
      end

      xmt_channel #(.CNT_W(CNT_W)) chan_i (
         .clk        (clk),
         .rst_n      (rst_n),
         .cnt_we     (cnt_we[i]),
         .match_we   (match_we[i]),
         .wdata      (wdata),
         .own_adv    (own_adv[i]),
         .src_adv    (src_adv[i]),
         .src_inc    (src_inc[i]),
         .rst_on_hit (ctrl_q[i][B_RST_ON_HIT]),
         .periodic   (ctrl_q[i][B_PERIODIC]),
         .hit        (hit[i]),
         .cnt_q      (cnt_q[i]),
         .match_q    (match_q[i])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      ien_q <= '0;
      else if (ien_we) ien_q <= wdata[NCH-1:0];
   end

   xmt_event #(.NEV(NCH)) event_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit      (hit),
      .ien      (ien_q),
      .clr_we   (status_clr),
      .clr_mask (wdata[NCH-1:0]),
      .events_q (events_q),
      .irq      (irq)
   );

   logic [NCH-1:0] snap_take;
   for (genvar i = 0; i < NCH; i++) begin : g_snap
      if (i >= NARROW_CH && (i % 2) == 1) begin : g_pair
         assign snap_take[i] = rd_en && grp == GRP_CNT && idx == IDX_W'(i)
                               && ctrl_q[i][B_SNAP_EN];
      end else begin : g_none
         assign snap_take[i] = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         snap_q <= '0;
      end else begin
         for (int i = 1; i < NCH; i++) begin
            if (snap_take[i]) snap_q <= cnt_q[i-1];
         end
      end
   end

   xmt_rdmux #(.CNT_W(CNT_W)) rdmux_i (
      .grp      (grp),
      .idx      (idx),
      .match_q  (match_q),
      .cnt_q    (cnt_q),
      .ctrl_q   (ctrl_q),
      .events_q (events_q),
      .ien_q    (ien_q),
      .snap_q   (snap_q),
      .data     (rd_data_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_data_c;
   end
endmodule

// File: rtl/xmt_checker.sv
module xmt_checker import xmt_pkg::*; #(
   parameter int CNT_W = 32
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       wr_en,
   input logic                       rd_en,
   input logic [4:0]                 addr,
   input logic [CNT_W-1:0]           wdata,
   input logic                       irq,
   input logic [NCH-1:0]             cnt_we,
   input logic [NCH-1:0]             match_we,
   input logic [NCH-1:0][CTRL_W-1:0] ctrl_q,
   input logic [NCH-1:0][CNT_W-1:0]  cnt_q,
   input logic [NCH-1:0]             hit,
   input logic [CNT_W-1:0]           snap_q
);
   // R11: irq only falls right after a status write
   assert_irq_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(wr_en && addr == 5'd24));

   // R10: snapshot changes only after a counter read
   assert_snap_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en && addr[4:3] == 2'd1) |=> $stable(snap_q));

   for (genvar i = 0; i < NCH; i++) begin : g_chk
      localparam bit MST = is_master(i);

      // R12: a counter write lands on the next edge
      assert_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_we[i] |=> cnt_q[i] == $past(wdata));

      // R2: rate code zero holds the counter
      assert_stop_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (ctrl_q[i][2:0] == 3'd0 && !cnt_we[i]) |=> $stable(cnt_q[i]));

      // R6: a slaved channel's own counter never moves by itself
      assert_slave_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (!MST && !ctrl_q[i][B_OWN] && !cnt_we[i]) |=> $stable(cnt_q[i]));

      // R8: reset on match clears the own counter
      assert_hit_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (hit[i] && (MST || ctrl_q[i][B_OWN]) && ctrl_q[i][B_RST_ON_HIT] && !cnt_we[i])
         |=> cnt_q[i] == '0);

      // R9: a one-shot channel cannot hit twice in a row without re-arming
      assert_oneshot_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (hit[i] && !ctrl_q[i][B_PERIODIC] && !match_we[i]) |=> !hit[i]);
   end
endmodule

bind xmatch_timer xmt_checker #(.CNT_W(CNT_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .rd_en    (rd_en),
   .addr     (addr),
   .wdata    (wdata),
   .irq      (irq),
   .cnt_we   (cnt_we),
   .match_we (match_we),
   .ctrl_q   (ctrl_q),
   .cnt_q    (cnt_q),
   .hit      (hit),
   .snap_q   (snap_q)
);

// File: tb/xmatch_timer_tb.sv
module xmatch_timer_tb_top;
   localparam int CNT_W = 32;
   localparam int NRATE = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_en = 1'b0;
   logic             rd_en = 1'b0;
   logic [4:0]       addr = '0;
   logic [CNT_W-1:0] wdata = '0;
   logic [CNT_W-1:0] rdata;
   logic [NRATE-1:1] rate_tick = '0;
   logic             irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   xmatch_timer #(.CNT_W(CNT_W), .NRATE(NRATE)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .rate_tick(rate_tick), .irq(irq)
   );

   localparam logic [4:0] A_STATUS = 5'd24, A_IEN = 5'd25, A_SNAP = 5'd26;
   function automatic logic [4:0] a_match(int i); return 5'(i);      endfunction
   function automatic logic [4:0] a_cnt(int i);   return 5'(8 + i);  endfunction
   function automatic logic [4:0] a_ctrl(int i);  return 5'(16 + i); endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic tick(input int line);
      @(negedge clk);
      rate_tick[line] = 1'b1;
      @(negedge clk);
      rate_tick = '0;
   endtask

   task automatic report;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         report();
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      chk("R1 irq", {31'd0, irq}, 32'd0);
      rd(A_STATUS, v); chk("R1 status", v, 0);
      rd(A_IEN, v);    chk("R1 ien", v, 0);
      rd(A_SNAP, v);   chk("R1 snap", v, 0);
      for (int i = 0; i < 8; i++) begin
         rd(a_cnt(i), v);   chk("R1 cnt", v, 0);
         rd(a_match(i), v); chk("R1 match", v, 0);
         rd(a_ctrl(i), v);  chk("R1 ctrl", v, 0);
      end

      // R2: every rate code against every tick line on channel 4
      for (int code = 0; code < 8; code++) begin
         for (int line = 1; line < 8; line++) begin
            wr(a_ctrl(0), 32'(code));
            wr(a_cnt(0), 0);
            tick(line);
            rd(a_cnt(0), v);
            chk("R2 rate", v, (code != 0 && code == line) ? 1 : 0);
         end
      end

      // R4: control width per channel group
      for (int i = 0; i < 8; i++) begin
         wr(a_ctrl(i), 32'hFFFF);
         rd(a_ctrl(i), v);
         chk("R4 ctrl width", v, (i < 4) ? 32'hFF : 32'h3FF);
         wr(a_ctrl(i), 0);
      end

      // R5: force-stop on channel 8, ignored on channel 4
      wr(a_ctrl(4), 32'h181); wr(a_cnt(4), 0); tick(1);
      rd(a_cnt(4), v); chk("R5 forced stop", v, 0);
      wr(a_ctrl(0), 32'h101); wr(a_cnt(0), 0); tick(1);
      rd(a_cnt(0), v); chk("R5 narrow ignores bit8", v, 1);
      wr(a_ctrl(4), 0); wr(a_ctrl(0), 0);

      // R12: load, and write wins over a tick in the same cycle
      wr(a_cnt(3), 32'hDEAD); rd(a_cnt(3), v); chk("R12 load", v, 32'hDEAD);
      wr(a_ctrl(0), 32'h1);
      @(negedge clk);
      addr = a_cnt(0); wdata = 5; wr_en = 1'b1; rate_tick[1] = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; rate_tick = '0;
      rd(a_cnt(0), v); chk("R12 write wins", v, 5);
      tick(1); rd(a_cnt(0), v); chk("R12 resume", v, 6);

      // R6/R7: channel 5 slaved to channel 4, enabled
      wr(a_cnt(0), 0); wr(a_ctrl(1), 0); wr(a_cnt(1), 0);
      wr(a_match(1), 3); wr(A_IEN, 32'h22);
      tick(1); tick(1);
      rd(A_STATUS, v); chk("R7 no early event", v, 0);
      tick(1);
      rd(A_STATUS, v); chk("R6 slave match", v, 32'h02);
      rd(a_cnt(1), v); chk("R6 slave counter idle", v, 0);
      chk("R11 irq high", {31'd0, irq}, 1);

      // R6: channel 9 follows channel 8
      wr(a_ctrl(4), 32'h2); wr(a_cnt(4), 0); wr(a_match(5), 2);
      tick(2); tick(2);
      rd(A_STATUS, v); chk("R6 ch9 follows ch8", v, 32'h22);

      // R11: clearing one of two events keeps irq high
      wr(A_STATUS, 32'h02);
      chk("R11 irq still high", {31'd0, irq}, 1);
      rd(A_STATUS, v); chk("R11 partial clear", v, 32'h20);
      wr(A_STATUS, 32'h20);
      chk("R11 irq low", {31'd0, irq}, 0);

      // R7: match without enable sets nothing
      wr(A_IEN, 0); wr(a_cnt(4), 0); tick(2); tick(2);
      rd(A_STATUS, v); chk("R7 disabled", v, 0);
      chk("R7 irq stays low", {31'd0, irq}, 0);
      wr(a_ctrl(4), 0);

      // R6: non-master channel with own bit counts itself
      wr(a_ctrl(5), 32'h82); wr(a_cnt(5), 7); tick(2);
      rd(a_cnt(5), v); chk("R6 own counter", v, 8);
      wr(a_ctrl(5), 0);

      // R8/R9: one-shot with reset on channel 6
      wr(A_IEN, 32'h04);
      wr(a_ctrl(2), 32'h89); wr(a_cnt(2), 0); wr(a_match(2), 2);
      tick(1); tick(1);
      rd(a_cnt(2), v);    chk("R8 reset on match", v, 0);
      rd(A_STATUS, v);    chk("R9 first hit", v, 32'h04);
      wr(A_STATUS, 32'h04);
      tick(1); tick(1);
      rd(A_STATUS, v);    chk("R9 one-shot silent", v, 0);
      rd(a_cnt(2), v);    chk("R8 no reset when disarmed", v, 2);
      wr(a_ctrl(2), 32'hC9); wr(a_match(2), 2); wr(a_cnt(2), 0);
      tick(1); tick(1);
      rd(A_STATUS, v);    chk("R9 periodic hit 1", v, 32'h04);
      wr(A_STATUS, 32'h04);
      tick(1); tick(1);
      rd(A_STATUS, v);    chk("R9 periodic hit 2", v, 32'h04);
      wr(A_STATUS, 32'h04); wr(a_ctrl(2), 0); wr(A_IEN, 0);

      // R10: snapshot on channels 9 and 11
      wr(a_ctrl(4), 0); wr(a_cnt(4), 32'h1234); wr(a_ctrl(5), 32'h200);
      rd(a_cnt(5), v);
      rd(A_SNAP, v); chk("R10 capture ch8", v, 32'h1234);
      wr(a_cnt(4), 32'h55); wr(a_ctrl(5), 0);
      rd(a_cnt(5), v);
      rd(A_SNAP, v); chk("R10 hold without bit9", v, 32'h1234);
      wr(a_ctrl(6), 0); wr(a_cnt(6), 32'hABC); wr(a_ctrl(7), 32'h200);
      rd(a_cnt(6), v);
      rd(A_SNAP, v); chk("R10 other reads keep snap", v, 32'h1234);
      rd(a_cnt(7), v);
      rd(A_SNAP, v); chk("R10 capture ch10", v, 32'hABC);

      // R3: address map corners
      wr(a_match(7), 32'h77); rd(a_match(7), v); chk("R3 match map", v, 32'h77);
      rd(5'd27, v); chk("R3 unmapped", v, 0);
      rd(5'd31, v); chk("R3 unmapped top", v, 0);

      done = 1'b1;
      report();
   end
endmodule